// File: doc/BRIEF.md
# Host Adapter Command Register Front End

This block is the register face that a host processor sees on an intelligent bus host adapter. Three byte-wide I/O locations are decoded. Location 0 reads back a status byte, and a write to it is a control byte. Location 1 takes an opcode followed by that opcode's parameter bytes, and a read of it returns response bytes. Location 2 is a read-only interrupt flags byte. Every register access is a single-cycle strobe: `wr_en` or `rd_en` together with `addr`.

Behind the ports, a parser takes in one written byte per clock. It looks up how many parameter bytes the opcode expects and range-checks the values that carry limits. It commits bus-on time, bus-off time, the transfer speed byte and the mailbox setup into a small settings store. Query opcodes play back their response bytes one at a time through a full/empty handshake. The identification, configuration and per-target LUN bytes come from elaboration parameters. The setup query is built from the live settings.

Completion, errors, the idle flag and the byte-port handshake flags all follow the byte count of the opcode in progress. A control write can clear the interrupt flags, signal a bus reset, or return the block to its default state.

Top module: `hp_regfront`

## Requirements
- R1: After `rst`, status (addr 0) reads 0x30 (bit 5 initialization-required, bit 4 idle, all others 0) and the interrupt byte (addr 2) reads 0x00. Status bits 1, 6 and 7 always read 0, and interrupt bits 0, 1, 4, 5 and 6 always read 0.
- R2: A data write (addr 1) sets status bit 3 (out-port full) in the cycle that follows the write edge. Outside a response phase, the parser consumes the byte at the next edge, which clears bit 3. Status bit 4 (idle) reads 0 from the opcode write until the command ends.
- R3: Parameter byte counts per opcode are: 0x00 none; 0x01 four; 0x05, 0x07, 0x08, 0x09, 0x0D and 0x1F one; 0x06 four; 0x0C two; 0x1A..0x1D three; 0x04, 0x0A and 0x0B none. When a command ends, idle returns to 1 and interrupt bit 2 (command complete) is set. Interrupt bit 7 reads 1 whenever any of bits 0..3 is 1.
- R4: Opcode 0x1F returns its one parameter byte unchanged as a single response byte.
- R5: Opcode 0x04 returns the 32-bit identification parameter, most significant byte first. Opcode 0x0B returns the 24-bit configuration parameter, most significant byte first. Opcode 0x0A returns eight LUN bitmask bytes: byte k of the 64-bit LUN parameter (bits 8k+7..8k) is the byte for target k, and target 0 comes first.
- R6: While a response byte waits, status bit 2 (in-port full) is 1. A read of addr 1 takes the byte and clears bit 2. The next byte, or the end of the command, follows on a later cycle.
- R7: Opcode 0x07 stores the bus-on time only if its value lies in 2..15. The value after reset is 11.
- R8: Opcode 0x08 stores the bus-off time only if its value lies in 1..64. The value after reset is 4.
- R9: Opcode 0x09 stores the speed byte only if it is 0..4 or has bit 7 set. The value after reset is 0.
- R10: Opcode 0x0D returns exactly N bytes, where N is its parameter. Bytes 0..7 are: flags (0x00), speed byte, bus-on, bus-off, mailbox count, then the mailbox address MSB, middle byte and LSB. Bytes beyond index 7 read 0. When N is 0, the command completes with no response byte.
- R11: An unknown opcode, or a value out of range, sets status bit 0 and the complete interrupt, returns to idle and leaves every setting unchanged. The next opcode write clears bit 0.
- R12: Opcode 0x01 stores the mailbox count and a 24-bit address, sent MSB first. It also clears status bit 5.
- R13: In a control write, bit 5 clears the interrupt byte and bit 4 pulses `bus_rst_o` for one cycle and sets interrupt bit 3. Control bits 3..0 have no effect.
- R14: A control write with bit 6 or bit 7 set restores default settings, clears the interrupt byte, abandons any command in progress, and sets status bits 5 and 4. Bit 7 also pulses `bus_rst_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 2 | Register location (0 status/control, 1 data/command, 2 interrupt) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the location on `addr` |
| bus_rst_o | output | 1 | One-cycle request to reset the attached bus |

## Verification
The assertions check these properties on every cycle:
- a pending command byte is taken up one edge later unless a response is in progress;
- no response byte is held while the parser is outside the response phase;
- completion is only reported once the parser is idle, and an error never commits settings;
- stored bus-on, bus-off and speed values never leave their legal sets;
- initialization-required only falls after a committed mailbox setup;
- the bus-reset interrupt only appears alongside the reset pulse.

The byte values played back by each query, the exact byte counts, and the recovery after resets and rejected parameters can only be shown by the bench's command scenarios. Those scenarios compare every response byte against values derived from the requirements.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_PARAM = 2'd1,
        PS_RESP  = 2'd2
    } pstate_e;

    localparam logic [7:0] OP_NOP    = 8'h00;
    localparam logic [7:0] OP_MBINIT = 8'h01;
    localparam logic [7:0] OP_IDENT  = 8'h04;
    localparam logic [7:0] OP_MBIE   = 8'h05;
    localparam logic [7:0] OP_SELTO  = 8'h06;
    localparam logic [7:0] OP_BUSON  = 8'h07;
    localparam logic [7:0] OP_BUSOFF = 8'h08;
    localparam logic [7:0] OP_SPEED  = 8'h09;
    localparam logic [7:0] OP_LUNS   = 8'h0A;
    localparam logic [7:0] OP_CONFIG = 8'h0B;
    localparam logic [7:0] OP_TARGET = 8'h0C;
    localparam logic [7:0] OP_SETUP  = 8'h0D;
    localparam logic [7:0] OP_ECHO   = 8'h1F;

    localparam int unsigned BUSON_MIN  = 2;
    localparam int unsigned BUSON_MAX  = 15;
    localparam int unsigned BUSON_DEF  = 11;
    localparam int unsigned BUSOFF_MIN = 1;
    localparam int unsigned BUSOFF_MAX = 64;
    localparam int unsigned BUSOFF_DEF = 4;
    localparam int unsigned SPEED_STD_MAX = 4;

    // Status bit positions
    localparam int ST_BADCMD = 0;
    localparam int ST_INFULL = 2;
    localparam int ST_OUTFUL = 3;
    localparam int ST_IDLE   = 4;
    localparam int ST_INITRQ = 5;

    // Control bit positions
    localparam int CT_BUSRST = 4;
    localparam int CT_INTCLR = 5;
    localparam int CT_SOFT   = 6;
    localparam int CT_HARD   = 7;

    typedef struct packed {
        logic       known;
        logic [2:0] nparam;
        logic [3:0] nresp;
        logic       resp_len_param;
    } opinfo_t;

    typedef struct packed {
        logic [7:0]  speed;
        logic [7:0]  buson;
        logic [7:0]  busoff;
        logic [7:0]  mbcount;
        logic [23:0] mbaddr;
    } settings_t;

    function automatic opinfo_t mk_info(logic k, logic [2:0] np, logic [3:0] nr, logic lp);
        opinfo_t r;
        r.known = k;
        r.nparam = np;
        r.nresp = nr;
        r.resp_len_param = lp;
        return r;
    endfunction

    function automatic opinfo_t op_lookup(logic [7:0] op);
        opinfo_t r;
        case (op)
            OP_NOP:    r = mk_info(1'b1, 3'd0, 4'd0, 1'b0);
            OP_MBINIT: r = mk_info(1'b1, 3'd4, 4'd0, 1'b0);
            OP_IDENT:  r = mk_info(1'b1, 3'd0, 4'd4, 1'b0);
            OP_MBIE:   r = mk_info(1'b1, 3'd1, 4'd0, 1'b0);
            OP_SELTO:  r = mk_info(1'b1, 3'd4, 4'd0, 1'b0);
            OP_BUSON, OP_BUSOFF, OP_SPEED:
                       r = mk_info(1'b1, 3'd1, 4'd0, 1'b0);
            OP_LUNS:   r = mk_info(1'b1, 3'd0, 4'd8, 1'b0);
            OP_CONFIG: r = mk_info(1'b1, 3'd0, 4'd3, 1'b0);
            OP_TARGET: r = mk_info(1'b1, 3'd2, 4'd0, 1'b0);
            OP_SETUP:  r = mk_info(1'b1, 3'd1, 4'd0, 1'b1);
            8'h1A, 8'h1B, 8'h1C, 8'h1D:
                       r = mk_info(1'b1, 3'd3, 4'd0, 1'b0);
            OP_ECHO:   r = mk_info(1'b1, 3'd1, 4'd1, 1'b0);
            default:   r = mk_info(1'b0, 3'd0, 4'd0, 1'b0);
        endcase
        return r;
    endfunction

    function automatic logic param_ok(logic [7:0] op, logic [7:0] v);
        case (op)
            OP_BUSON:  return (32'(v) >= BUSON_MIN) && (32'(v) <= BUSON_MAX);
            OP_BUSOFF: return (32'(v) >= BUSOFF_MIN) && (32'(v) <= BUSOFF_MAX);
            OP_SPEED:  return (32'(v) <= SPEED_STD_MAX) || v[7];
            default:   return 1'b1;
        endcase
    endfunction

    function automatic settings_t settings_default();
        settings_t s;
        s.speed   = 8'h00;
        s.buson   = 8'(BUSON_DEF);
        s.busoff  = 8'(BUSOFF_DEF);
        s.mbcount = 8'h00;
        s.mbaddr  = 24'h0;
        return s;
    endfunction

endpackage

// File: rtl/hp_parser.sv
module hp_parser
    import hp_pkg::*;
#(
    parameter int NPMAX = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sreset_i,
    input  logic               ob_valid_i,
    input  logic [7:0]         ob_byte_i,
    input  logic               ib_taken_i,
    input  logic [7:0]         resp_byte_i,
    output logic               consume_o,
    output pstate_e            state_o,
    output logic [7:0]         op_o,
    output logic [NPMAX*8-1:0] pbuf_o,
    output logic [7:0]         ridx_o,
    output logic               in_full_o,
    output logic [7:0]         in_byte_o,
    output logic               apply_o,
    output logic               done_o,
    output logic               err_o
);
    localparam int CW = $clog2(NPMAX + 1);

    pstate_e     state_q;
    logic [7:0]  op_q;
    logic [7:0]  pbuf_q [NPMAX];
    logic [CW-1:0] cnt_q;
    logic [7:0]  rlen_q;
    logic [7:0]  ridx_q;
    logic        in_full_q;
    logic [7:0]  in_byte_q;
    logic        apply_q;
    logic        done_q;
    logic        err_q;

    opinfo_t     cur_info;
    opinfo_t     new_info;
    logic        last_param;
    logic [7:0]  p0_eff;
    logic        p_ok;

    always_comb begin
        cur_info   = op_lookup(op_q);
        new_info   = op_lookup(ob_byte_i);
        last_param = (32'(cnt_q) + 32'd1) == 32'(cur_info.nparam);
        p0_eff     = (cnt_q == '0) ? ob_byte_i : pbuf_q[0];
        p_ok       = param_ok(op_q, p0_eff);
        consume_o  = ob_valid_i && (state_q != PS_RESP);
    end

    always_ff @(posedge clk) begin
        if (rst || sreset_i) begin
            state_q   <= PS_IDLE;
            op_q      <= 8'h00;
            cnt_q     <= '0;
            rlen_q    <= 8'h00;
            ridx_q    <= 8'h00;
            in_full_q <= 1'b0;
            in_byte_q <= 8'h00;
            apply_q   <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            for (int i = 0; i < NPMAX; i++) pbuf_q[i] <= 8'h00;
        end else begin
            apply_q <= 1'b0;
            done_q  <= 1'b0;
            if (ib_taken_i) in_full_q <= 1'b0;
            case (state_q)
                PS_IDLE: begin
                    if (ob_valid_i) begin
                        op_q   <= ob_byte_i;
                        err_q  <= 1'b0;
                        cnt_q  <= '0;
                        ridx_q <= 8'h00;
                        if (!new_info.known) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else if (new_info.nparam != 3'd0) begin
                            state_q <= PS_PARAM;
                        end else if (new_info.nresp != 4'd0) begin
                            state_q <= PS_RESP;
                            rlen_q  <= {4'h0, new_info.nresp};
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                PS_PARAM: begin
                    if (ob_valid_i) begin
                        for (int i = 0; i < NPMAX; i++)
                            if (CW'(i) == cnt_q) pbuf_q[i] <= ob_byte_i;
                        cnt_q <= cnt_q + 1'b1;
                        if (last_param) begin
                            if (!p_ok) begin
                                err_q   <= 1'b1;
                                done_q  <= 1'b1;
                                state_q <= PS_IDLE;
                            end else begin
                                apply_q <= 1'b1;
                                if (cur_info.resp_len_param) begin
                                    rlen_q <= p0_eff;
                                    if (p0_eff == 8'h00) begin
                                        done_q  <= 1'b1;
                                        state_q <= PS_IDLE;
                                    end else begin
                                        state_q <= PS_RESP;
                                    end
                                end else if (cur_info.nresp != 4'd0) begin
                                    rlen_q  <= {4'h0, cur_info.nresp};
                                    state_q <= PS_RESP;
                                end else begin
                                    done_q  <= 1'b1;
                                    state_q <= PS_IDLE;
                                end
                            end
                        end
                    end
                end
                PS_RESP: begin
                    if (!in_full_q) begin
                        if (ridx_q == rlen_q) begin
                            done_q  <= 1'b1;
                            state_q <= PS_IDLE;
                        end else begin
                            in_byte_q <= resp_byte_i;
                            in_full_q <= 1'b1;
                            ridx_q    <= ridx_q + 8'd1;
                        end
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < NPMAX; g++) begin : g_pbuf
        assign pbuf_o[g*8 +: 8] = pbuf_q[g];
    end

    assign state_o   = state_q;
    assign op_o      = op_q;
    assign ridx_o    = ridx_q;
    assign in_full_o = in_full_q;
    assign in_byte_o = in_byte_q;
    assign apply_o   = apply_q;
    assign done_o    = done_q;
    assign err_o     = err_q;

    // R6: a response byte is only held during the response phase
    assert_no_byte_outside_resp_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_RESP) |-> !in_full_q);

    // R3: completion is reported only once the parser is back at idle
    assert_done_at_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (state_q == PS_IDLE));

    // R11: a rejected command never commits settings
    assert_err_no_apply_R11: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !apply_q);

endmodule

// File: rtl/hp_settings.sv
module hp_settings
    import hp_pkg::*;
#(
    parameter int NPMAX = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sreset_i,
    input  logic               apply_i,
    input  logic [7:0]         op_i,
    input  logic [NPMAX*8-1:0] pbuf_i,
    output settings_t          set_o,
    output logic               init_req_o
);
    settings_t set_q;
    logic      init_req_q;
    logic [7:0] p0, p1, p2, p3;

    always_comb begin
        p0 = pbuf_i[7:0];
        p1 = pbuf_i[15:8];
        p2 = pbuf_i[23:16];
        p3 = pbuf_i[31:24];
    end

    always_ff @(posedge clk) begin
        if (rst || sreset_i) begin
            set_q      <= settings_default();
            init_req_q <= 1'b1;
        end else if (apply_i) begin
            case (op_i)
                OP_BUSON:  set_q.buson  <= p0;
                OP_BUSOFF: set_q.busoff <= p0;
                OP_SPEED:  set_q.speed  <= p0;
                OP_MBINIT: begin
                    set_q.mbcount <= p0;
                    set_q.mbaddr  <= {p1, p2, p3};
                    init_req_q    <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign set_o      = set_q;
    assign init_req_o = init_req_q;

    assert_buson_range_R7: assert property (@(posedge clk) disable iff (rst)
        (32'(set_q.buson) >= BUSON_MIN) && (32'(set_q.buson) <= BUSON_MAX));

    assert_busoff_range_R8: assert property (@(posedge clk) disable iff (rst)
        (32'(set_q.busoff) >= BUSOFF_MIN) && (32'(set_q.busoff) <= BUSOFF_MAX));

    assert_speed_legal_R9: assert property (@(posedge clk) disable iff (rst)
        (32'(set_q.speed) <= SPEED_STD_MAX) || set_q.speed[7]);

    assert_init_clear_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(init_req_q) |-> $past(apply_i && (op_i == OP_MBINIT)));

endmodule

// File: rtl/hp_resp.sv
module hp_resp
    import hp_pkg::*;
#(
    parameter logic [31:0] ID_WORD  = 32'h4142_2031,
    parameter logic [23:0] CFG_WORD = 24'h20_08_07,
    parameter logic [63:0] LUN_MAP  = 64'h8000_0000_0F00_0201
) (
    input  logic [7:0] op_i,
    input  logic [7:0] ridx_i,
    input  logic [7:0] p0_i,
    input  settings_t  set_i,
    output logic [7:0] byte_o
);
    logic [7:0] id_b, cfg_b, lun_b, setup_b;

    always_comb begin
        case (ridx_i)
            8'd0:    id_b = ID_WORD[31:24];
            8'd1:    id_b = ID_WORD[23:16];
            8'd2:    id_b = ID_WORD[15:8];
            default: id_b = ID_WORD[7:0];
        endcase
        case (ridx_i)
            8'd0:    cfg_b = CFG_WORD[23:16];
            8'd1:    cfg_b = CFG_WORD[15:8];
            default: cfg_b = CFG_WORD[7:0];
        endcase
        lun_b = LUN_MAP[{ridx_i[2:0], 3'b000} +: 8];
        case (ridx_i)
            8'd0:    setup_b = 8'h00;
            8'd1:    setup_b = set_i.speed;
            8'd2:    setup_b = set_i.buson;
            8'd3:    setup_b = set_i.busoff;
            8'd4:    setup_b = set_i.mbcount;
            8'd5:    setup_b = set_i.mbaddr[23:16];
            8'd6:    setup_b = set_i.mbaddr[15:8];
            8'd7:    setup_b = set_i.mbaddr[7:0];
            default: setup_b = 8'h00;
        endcase
        case (op_i)
            OP_IDENT:  byte_o = id_b;
            OP_CONFIG: byte_o = cfg_b;
            OP_LUNS:   byte_o = lun_b;
            OP_SETUP:  byte_o = setup_b;
            OP_ECHO:   byte_o = p0_i;
            default:   byte_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/hp_regfront.sv
module hp_regfront
    import hp_pkg::*;
#(
    parameter logic [31:0] ID_WORD  = 32'h4142_2031,
    parameter logic [23:0] CFG_WORD = 24'h20_08_07,
    parameter logic [63:0] LUN_MAP  = 64'h8000_0000_0F00_0201,
    parameter int          NPMAX    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       bus_rst_o
);
    localparam logic [1:0] A_CTL  = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_INTR = 2'd2;

    logic       ctl_wr, data_wr, sreset, intclr, busev;
    logic       out_full_q;
    logic [7:0] out_byte_q;
    logic       consume, ib_taken;
    pstate_e    pstate;
    logic [7:0] op, ridx, in_byte, resp_byte;
    logic [NPMAX*8-1:0] pbuf;
    logic       in_full, apply, done, err;
    settings_t  set;
    logic       init_req;
    logic       done_flag_q, rst_seen_q, bus_rst_q;
    logic       idle;
    logic [7:0] status_b, intr_b;

    always_comb begin
        ctl_wr   = wr_en && (addr == A_CTL);
        data_wr  = wr_en && (addr == A_DATA);
        sreset   = ctl_wr && (wdata[CT_SOFT] || wdata[CT_HARD]);
        intclr   = ctl_wr && wdata[CT_INTCLR];
        busev    = ctl_wr && wdata[CT_BUSRST];
        ib_taken = rd_en && (addr == A_DATA) && in_full;
    end

    always_ff @(posedge clk) begin
        if (rst || sreset) begin
            out_full_q <= 1'b0;
            out_byte_q <= 8'h00;
        end else if (data_wr && !out_full_q) begin
            out_full_q <= 1'b1;
            out_byte_q <= wdata;
        end else if (consume) begin
            out_full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rst_q <= 1'b0;
        end else begin
            bus_rst_q <= ctl_wr && (wdata[CT_BUSRST] || wdata[CT_HARD]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sreset) begin
            done_flag_q <= 1'b0;
            rst_seen_q  <= 1'b0;
        end else begin
            done_flag_q <= (done_flag_q && !intclr) || done;
            rst_seen_q  <= (rst_seen_q && !intclr) || busev;
        end
    end

    hp_parser #(.NPMAX(NPMAX)) u_parser (
        .clk         (clk),
        .rst         (rst),
        .sreset_i    (sreset),
        .ob_valid_i  (out_full_q),
        .ob_byte_i   (out_byte_q),
        .ib_taken_i  (ib_taken),
        .resp_byte_i (resp_byte),
        .consume_o   (consume),
        .state_o     (pstate),
        .op_o        (op),
        .pbuf_o      (pbuf),
        .ridx_o      (ridx),
        .in_full_o   (in_full),
        .in_byte_o   (in_byte),
        .apply_o     (apply),
        .done_o      (done),
        .err_o       (err)
    );

    hp_settings #(.NPMAX(NPMAX)) u_settings (
        .clk        (clk),
        .rst        (rst),
        .sreset_i   (sreset),
        .apply_i    (apply),
        .op_i       (op),
        .pbuf_i     (pbuf),
        .set_o      (set),
        .init_req_o (init_req)
    );

    hp_resp #(.ID_WORD(ID_WORD), .CFG_WORD(CFG_WORD), .LUN_MAP(LUN_MAP)) u_resp (
        .op_i   (op),
        .ridx_i (ridx),
        .p0_i   (pbuf[7:0]),
        .set_i  (set),
        .byte_o (resp_byte)
    );

    always_comb begin
        idle     = (pstate == PS_IDLE) && !out_full_q;
        status_b = 8'h00;
        status_b[ST_BADCMD] = err;
        status_b[ST_INFULL] = in_full;
        status_b[ST_OUTFUL] = out_full_q;
        status_b[ST_IDLE]   = idle;
        status_b[ST_INITRQ] = init_req;
        intr_b = {done_flag_q || rst_seen_q, 3'b000, rst_seen_q, done_flag_q, 2'b00};
        case (addr)
            A_CTL:   rdata = status_b;
            A_DATA:  rdata = in_byte;
            A_INTR:  rdata = intr_b;
            default: rdata = 8'h00;
        endcase
    end

    assign bus_rst_o = bus_rst_q;

    // R2: a pending byte outside the response phase is taken at the next edge
    assert_consume_next_R2: assert property (@(posedge clk) disable iff (rst)
        (out_full_q && (pstate != PS_RESP)) |=> !out_full_q);

    // R13: the bus-reset interrupt only rises together with the reset pulse
    assert_busrst_flag_R13: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_seen_q) |-> bus_rst_q);

endmodule

// File: tb/hp_regfront_test.sv
`timescale 1ns/1ps
module hp_regfront_test;
    localparam logic [31:0] T_ID  = 32'h5A31_C207;
    localparam logic [23:0] T_CFG = 24'h11_42_06;
    localparam logic [63:0] T_LUN = 64'h8000_3300_0F00_0201;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       bus_rst_o;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       rd_evt;

    always #5 clk = ~clk;

    hp_regfront #(.ID_WORD(T_ID), .CFG_WORD(T_CFG), .LUN_MAP(T_LUN)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .bus_rst_o(bus_rst_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic push(input string req, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // scoreboard monitor: compares every data-port read with the queue head
    always @(rd_evt) begin
        if (exp_q.size() == 0) begin
            total++;
            bad++;
            $display("FAIL R6: unexpected response byte actual=%02h expected=none", rdata);
        end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(t, rdata, e);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic rd();
        @(negedge clk);
        addr = 2'd1; rd_en = 1'b1;
        #1;
        -> rd_evt;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic go(input logic [7:0] op);
        wr(2'd0, 8'h20);
        wr(2'd1, op);
    endtask

    task automatic get_resp(input int n, input string req);
        logic [7:0] s;
        for (int i = 0; i < n; i++) begin
            s = 8'h00;
            for (int k = 0; k < 200; k++) begin
                peek(2'd0, s);
                if (s[2]) break;
                @(negedge clk);
            end
            if (!s[2]) chk(req, 8'h00, 8'h04);
            else rd();
        end
    endtask

    task automatic wait_done(input string req);
        logic [7:0] v;
        v = 8'h00;
        for (int k = 0; k < 200; k++) begin
            peek(2'd2, v);
            if (v[2]) break;
            @(negedge clk);
        end
        chk(req, {7'd0, v[2]}, 8'h01);
    endtask

    task automatic setup_query(input int n);
        go(8'h0D);
        wr(2'd1, 8'(n));
        get_resp(n, "R10");
        wait_done("R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] s0;
        logic [7:0] i0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, v); chk("R1", v, 8'h30);
        peek(2'd2, v); chk("R1", v, 8'h00);

        // R2 out-port full for one cycle, idle low through the command
        go(8'h07);
        peek(2'd0, v); chk("R2", v, 8'h28);
        @(negedge clk);
        peek(2'd0, v); chk("R2", v, 8'h20);
        wr(2'd1, 8'd7);
        wait_done("R3");
        peek(2'd0, v); chk("R3", v, 8'h30);
        peek(2'd2, v); chk("R3", v, 8'h84);

        // R7 / R10 stored bus-on visible in setup
        push("R10", 8'h00); push("R9", 8'h00); push("R7", 8'd7);
        push("R8", 8'd4); push("R10", 8'h00);
        setup_query(5);

        // R7 / R11 out-of-range bus-on rejected
        go(8'h07); wr(2'd1, 8'd16);
        wait_done("R11");
        peek(2'd0, v); chk("R11", v & 8'h01, 8'h01);
        go(8'h07); wr(2'd1, 8'd1);
        wait_done("R11");
        push("R10", 8'h00); push("R9", 8'h00); push("R7", 8'd7); push("R8", 8'd4);
        setup_query(4);
        peek(2'd0, v); chk("R11", v & 8'h01, 8'h00);

        // R8 bus-off limits
        go(8'h08); wr(2'd1, 8'd0); wait_done("R8");
        peek(2'd0, v); chk("R8", v & 8'h01, 8'h01);
        go(8'h08); wr(2'd1, 8'd64); wait_done("R8");
        go(8'h08); wr(2'd1, 8'd65); wait_done("R8");
        push("R10", 8'h00); push("R9", 8'h00); push("R7", 8'd7); push("R8", 8'd64);
        setup_query(4);

        // R9 speed byte
        go(8'h09); wr(2'd1, 8'h05); wait_done("R9");
        peek(2'd0, v); chk("R9", v & 8'h01, 8'h01);
        go(8'h09); wr(2'd1, 8'h83); wait_done("R9");
        push("R10", 8'h00); push("R9", 8'h83);
        setup_query(2);

        // R11 unknown opcode
        go(8'h55);
        wait_done("R11");
        peek(2'd0, v); chk("R11", v, 8'h31);

        // R4 echo
        push("R4", 8'hA5);
        go(8'h1F); wr(2'd1, 8'hA5); get_resp(1, "R4"); wait_done("R4");
        push("R4", 8'h00);
        go(8'h1F); wr(2'd1, 8'h00); get_resp(1, "R4"); wait_done("R4");

        // R5 / R6 identification with manual handshake check
        push("R5", T_ID[31:24]); push("R5", T_ID[23:16]);
        push("R5", T_ID[15:8]);  push("R5", T_ID[7:0]);
        go(8'h04);
        repeat (3) @(negedge clk);
        peek(2'd0, v); chk("R6", v & 8'h14, 8'h04);
        rd();
        peek(2'd0, v); chk("R6", v & 8'h04, 8'h00);
        get_resp(3, "R5");
        wait_done("R5");

        push("R5", T_CFG[23:16]); push("R5", T_CFG[15:8]); push("R5", T_CFG[7:0]);
        go(8'h0B); get_resp(3, "R5"); wait_done("R5");

        for (int t = 0; t < 8; t++) push("R5", T_LUN[t*8 +: 8]);
        go(8'h0A); get_resp(8, "R5"); wait_done("R5");

        // R3 parameter counts: three-byte opcode then two-byte opcode
        go(8'h1C); wr(2'd1, 8'h01); wr(2'd1, 8'h02);
        repeat (3) @(negedge clk);
        peek(2'd0, v); chk("R3", v & 8'h10, 8'h00);
        wr(2'd1, 8'h03); wait_done("R3");
        go(8'h0C); wr(2'd1, 8'h01); wr(2'd1, 8'h0F); wait_done("R3");
        peek(2'd0, v); chk("R3", v, 8'h30);

        // R12 mailbox setup
        go(8'h01); wr(2'd1, 8'h03); wr(2'd1, 8'h12); wr(2'd1, 8'h34); wr(2'd1, 8'h56);
        wait_done("R12");
        peek(2'd0, v); chk("R12", v, 8'h10);
        push("R10", 8'h00); push("R9", 8'h83); push("R7", 8'd7); push("R8", 8'd64);
        push("R12", 8'h03); push("R12", 8'h12); push("R12", 8'h34); push("R12", 8'h56);
        setup_query(8);
        push("R10", 8'h00); push("R9", 8'h83); push("R7", 8'd7); push("R8", 8'd64);
        push("R12", 8'h03); push("R12", 8'h12); push("R12", 8'h34); push("R12", 8'h56);
        push("R10", 8'h00); push("R10", 8'h00);
        setup_query(10);

        // R10 zero-length setup
        go(8'h0D); wr(2'd1, 8'h00);
        wait_done("R10");
        peek(2'd0, v); chk("R10", v, 8'h10);

        // R13 control low bits ignored, then bus reset and clear
        peek(2'd0, s0); peek(2'd2, i0);
        wr(2'd0, 8'h0F);
        peek(2'd0, v); chk("R13", v, s0);
        peek(2'd2, v); chk("R13", v, i0);
        chk("R13", {7'd0, bus_rst_o}, 8'h00);
        wr(2'd0, 8'h20);
        wr(2'd0, 8'h10);
        chk("R13", {7'd0, bus_rst_o}, 8'h01);
        peek(2'd2, v); chk("R13", v, 8'h88);
        @(negedge clk);
        chk("R13", {7'd0, bus_rst_o}, 8'h00);
        wr(2'd0, 8'h20);
        peek(2'd2, v); chk("R13", v, 8'h00);

        // R14 soft reset restores defaults
        wr(2'd0, 8'h10);
        wr(2'd0, 8'h40);
        peek(2'd0, v); chk("R14", v, 8'h30);
        peek(2'd2, v); chk("R14", v, 8'h00);
        push("R14", 8'h00); push("R14", 8'h00); push("R14", 8'd11);
        push("R14", 8'd4);  push("R14", 8'h00);
        setup_query(5);

        // R14 hard reset abandons a command and pulses bus reset
        go(8'h07);
        wr(2'd0, 8'h80);
        chk("R14", {7'd0, bus_rst_o}, 8'h01);
        peek(2'd0, v); chk("R14", v, 8'h30);
        peek(2'd2, v); chk("R14", v, 8'h00);
        push("R14", 8'h3C);
        go(8'h1F); wr(2'd1, 8'h3C); get_resp(1, "R14"); wait_done("R14");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) chk("R6", 8'(exp_q.size()), 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule